// File: doc/BRIEF.md
# Network Clock Carrier and Collision Gate

This block qualifies transmission on a shared serial network for a local serial link controller. It watches the network clock line, sampled in the system clock domain, and raises a carrier-present indication for as long as that line keeps toggling. A retriggerable idle counter measures the time since the last transition in system clocks. When the counter reaches a limit set at run time, the carrier indication drops. The first transition after that restores it.

A second input carries a logic-level collision flag from an external line-level comparator. That flag is asserted when more than one station drives the line at the same time. Clear-to-send is the AND of "carrier present" and "no collision". Losing the clock or seeing a collision therefore stops transmission without waiting for the other condition.

A sticky collision bit records that a collision happened, so that retry logic can act on it later. A one-cycle clear strobe resets the bit. No data passes through the block, so it has no valid/ready stream. Every pin is a plain control or status level, and there is no back-pressure.

Top module: `ncg_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, carrier_o, cts_o and coll_sticky_o are all low.
- R2: After reset, carrier_o goes high within 6 system clocks of a transition (rising or falling) on net_clk_i. Transitions that happen during reset or within 3 cycles of its release are ignored.
- R3: carrier_o stays high while net_clk_i transitions at intervals shorter than idle_limit_i system clocks.
- R4: When net_clk_i has had no transition for more than idle_limit_i + 4 system clocks, carrier_o is low. It stays low until the next transition on net_clk_i.
- R5: cts_o is high when carrier is present and coll_flag_i has been low for at least 4 cycles.
- R6: When coll_flag_i is high, cts_o is low within 4 system clocks, even if net_clk_i keeps toggling.
- R7: When the network clock is lost (R4), cts_o is low even though coll_flag_i is low.
- R8: coll_sticky_o goes high within 4 cycles of coll_flag_i rising. It stays high after coll_flag_i falls.
- R9: A one-cycle high on coll_clear_i clears coll_sticky_o, provided the synchronised collision flag is low. While the collision is still active, the clear has no effect and the bit remains high.
- R10: idle_limit_i is read live. Raising it lengthens the timeout: with a limit of 40, carrier_o is still high 28 cycles after the clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_clk_i | input | 1 | Network clock line, asynchronous |
| coll_flag_i | input | 1 | Collision flag from the line comparator, asynchronous, active high |
| idle_limit_i | input | CNT_W | Number of system clocks without a transition before carrier is lost |
| coll_clear_i | input | 1 | Write-one-to-clear strobe for the sticky collision bit |
| carrier_o | output | 1 | Carrier present, registered |
| cts_o | output | 1 | Clear-to-send, registered |
| coll_sticky_o | output | 1 | Sticky collision status, registered |

## Verification
The hardest case to reach is the boundary of the idle window. The network clock has to stop in a known cycle, and the bench then has to tell "just inside the limit" apart from "just past it" even though the synchroniser and edge registers add latency. The stimulus toggles net_clk_i from a background generator that a task can halt. It then samples carrier_o at points well inside and well past the window, first with a small limit and then with a raised one. A clear strobe issued while a collision is still being held is the other case that is hard to reach. It is covered by holding coll_flag_i high across the strobe.

// File: rtl/ncg_pkg.sv
`timescale 1ns/1ps
package ncg_pkg;
  // Default number of synchroniser flops on each asynchronous input.
  localparam int unsigned SYNC_DEPTH = 2;

  // Saturating increment for idle counters of any width up to 32 bits.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] top_val;
    top_val = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= top_val) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/ncg_sync.sv
`timescale 1ns/1ps
module ncg_sync #(
  parameter int unsigned STAGES = ncg_pkg::SYNC_DEPTH,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ncg_activity_mon.sv
`timescale 1ns/1ps
module ncg_activity_mon #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGES = ncg_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_s,
  input  logic [CNT_W-1:0] limit_i,
  output logic             present_o
);
  localparam int unsigned WARM_W = $clog2(STAGES + 2);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(STAGES + 1);

  logic              prev_q;
  logic [WARM_W-1:0] warm_q;
  logic              armed;
  logic              edge_seen;
  logic [CNT_W-1:0]  idle_q;
  logic              present_q;

  assign armed     = (warm_q == WARM_END);
  assign edge_seen = armed && (line_s != prev_q);

  // Warm-up: the synchroniser must fill before edges are trusted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= line_s;
      if (!armed) warm_q <= warm_q + 1'b1;
    end
  end

  // Retriggerable idle counter and the carrier state.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q    <= '0;
      present_q <= 1'b0;
    end else if (edge_seen) begin
      idle_q    <= '0;
      present_q <= 1'b1;
    end else if (idle_q >= limit_i) begin
      present_q <= 1'b0;
    end else begin
      idle_q <= CNT_W'(ncg_pkg::sat_inc(32'(idle_q), CNT_W));
    end
  end

  assign present_o = present_q;

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> present_q);
  assert_timeout_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && idle_q >= limit_i) |=> !present_q);
  assert_stays_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!present_q && !edge_seen) |=> !present_q);
endmodule

// File: rtl/ncg_collision_tracker.sv
`timescale 1ns/1ps
module ncg_collision_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic coll_s,
  input  logic clear_i,
  output logic sticky_o
);
  logic sticky_q;

  // A live collision wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       sticky_q <= 1'b0;
    else if (coll_s)  sticky_q <= 1'b1;
    else if (clear_i) sticky_q <= 1'b0;
  end

  assign sticky_o = sticky_q;

  assert_sticky_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_s |=> sticky_q);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clear_i) |=> sticky_q);
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !coll_s) |=> !sticky_q);
endmodule

// File: rtl/ncg_gate.sv
`timescale 1ns/1ps
module ncg_gate #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGES = ncg_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             net_clk_i,
  input  logic             coll_flag_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  input  logic             coll_clear_i,
  output logic             carrier_o,
  output logic             cts_o,
  output logic             coll_sticky_o
);
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic       line_s;
  logic       coll_s;
  logic       present;
  logic       cts_q;

  assign raw_in = {coll_flag_i, net_clk_i};

  ncg_sync #(.STAGES(STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(synced)
  );

  assign line_s = synced[0];
  assign coll_s = synced[1];

  ncg_activity_mon #(.CNT_W(CNT_W), .STAGES(STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .line_s(line_s),
    .limit_i(idle_limit_i), .present_o(present)
  );

  ncg_collision_tracker u_coll (
    .clk(clk), .rst_n(rst_n), .coll_s(coll_s),
    .clear_i(coll_clear_i), .sticky_o(coll_sticky_o)
  );

  // Either fault condition alone withholds clear-to-send.
  always_ff @(posedge clk) begin
    if (!rst_n) cts_q <= 1'b0;
    else        cts_q <= present & ~coll_s;
  end

  assign carrier_o = present;
  assign cts_o     = cts_q;

  assert_cts_needs_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_q |-> $past(present));
  assert_collision_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coll_s |=> !cts_q);
  assert_cts_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (present && !coll_s) |=> cts_q);
endmodule

// File: tb/ncg_gate_test.sv
`timescale 1ns/1ps
module ncg_gate_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic net_clk = 1'b0;
  logic coll = 1'b0;
  logic clr = 1'b0;
  logic [CNT_W-1:0] limit = 16'd16;
  logic carrier, cts, sticky;

  int n_checks = 0;
  int n_fail = 0;
  bit run_clk = 1'b0;
  int half = 3;
  int hp_cnt = 0;

  always #2.5 clk = ~clk;

  ncg_gate #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .net_clk_i(net_clk), .coll_flag_i(coll),
    .idle_limit_i(limit), .coll_clear_i(clr),
    .carrier_o(carrier), .cts_o(cts), .coll_sticky_o(sticky)
  );

  // Background network clock generator, halted by clearing run_clk.
  always @(negedge clk) begin
    if (run_clk) begin
      if (hp_cnt >= half - 1) begin
        net_clk <= ~net_clk;
        hp_cnt  <= 0;
      end else begin
        hp_cnt <= hp_cnt + 1;
      end
    end
  end

  task automatic check(input bit actual, input bit expected, input string what);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", what, actual, expected);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cycles(3);
    check(carrier, 1'b0, "R1 carrier in reset");
    check(cts, 1'b0, "R1 cts in reset");
    check(sticky, 1'b0, "R1 sticky in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(carrier, 1'b0, "R1 carrier after release");
    check(cts, 1'b0, "R1 cts after release");
    wait_cycles(5);
  endtask

  task automatic t_carrier_up;
    net_clk = ~net_clk;
    wait_cycles(6);
    check(carrier, 1'b1, "R2 carrier after first edge");
    run_clk = 1'b1;
    wait_cycles(4);
    check(cts, 1'b1, "R5 cts with carrier and no collision");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 8; i++) begin
      wait_cycles(7);
      check(carrier, 1'b1, "R3 carrier held while toggling");
    end
  endtask

  task automatic t_timeout;
    run_clk = 1'b0;
    wait_cycles(8);
    check(carrier, 1'b1, "R4 carrier inside idle window");
    wait_cycles(25);
    check(carrier, 1'b0, "R4 carrier lost after idle window");
    check(cts, 1'b0, "R7 cts withheld on clock loss");
    wait_cycles(30);
    check(carrier, 1'b0, "R4 carrier stays low without edge");
  endtask

  task automatic t_restore;
    run_clk = 1'b1;
    wait_cycles(10);
    check(carrier, 1'b1, "R4 carrier restored on edge");
    check(cts, 1'b1, "R5 cts restored");
  endtask

  task automatic t_collision;
    coll = 1'b1;
    wait_cycles(4);
    check(cts, 1'b0, "R6 cts blocked by collision");
    check(carrier, 1'b1, "R6 carrier unaffected by collision");
    check(sticky, 1'b1, "R8 sticky set");
    wait_cycles(20);
    check(cts, 1'b0, "R6 cts held low during collision");
    coll = 1'b0;
    wait_cycles(5);
    check(cts, 1'b1, "R5 cts back after collision");
    check(sticky, 1'b1, "R8 sticky held after collision");
  endtask

  task automatic t_clear_blocked;
    coll = 1'b1;
    wait_cycles(5);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    wait_cycles(2);
    check(sticky, 1'b1, "R9 clear ignored during collision");
    coll = 1'b0;
    wait_cycles(5);
    check(sticky, 1'b1, "R9 sticky kept until clear");
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check(sticky, 1'b0, "R9 clear strobe clears");
  endtask

  task automatic t_limit_change;
    limit = 16'd40;
    wait_cycles(10);
    run_clk = 1'b0;
    wait_cycles(28);
    check(carrier, 1'b1, "R10 longer limit keeps carrier");
    wait_cycles(30);
    check(carrier, 1'b0, "R10 carrier lost after longer limit");
    check(cts, 1'b0, "R7 cts low after longer timeout");
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_carrier_up();
    t_hold();
    t_timeout();
    t_restore();
    t_collision();
    t_clear_blocked();
    t_limit_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule